// File: doc/BRIEF.md
# I2C Bus Capture Monitor

This block listens to the SCL and SDA lines of an I2C bus without ever driving them. Once armed, it takes a snapshot of both lines once every programmed number of clock cycles. The snapshots go into an internal sample memory until the programmed number of samples has been stored. While it captures, it also decodes the bus. Each SCL rising edge yields a data bit. START and STOP conditions are marked, so a packet can be delimited from its START to its STOP. The ninth bit after each START-aligned byte is flagged as the acknowledge slot. Each decoded event is written into an event log together with the sample position at which it occurred.

There are two ways to arm the block. In free-run mode, sampling begins right away. In triggered mode, the block waits idle until it sees a START condition, and that START becomes the first logged event. A small register interface is used to:
- set the sampling period and the sample count;
- arm the block and read its status;
- read the sample memory and the event log by index.

Both bus lines pass through two-flop synchronizers before any decoding.

Top module: `i2c_capture_monitor`

## Requirements
- R1: After reset the status register (address 0) reads 0, the event count (address 7) reads 0 and the period register (address 1) reads 0.
- R2: The period register (address 1) and count register (address 2) read back the last value written to them.
- R3: While capturing, one sample is stored every P cycles, where P is the latched period and a period of 0 counts as 1. Sample j is written on the edge that falls (j+1)*P cycles after the capture start. It holds SCL in bit 1 and SDA in bit 0, as the lines stood at the clock edge two cycles before that write. Samples are read at address 4 after the sample index is written at address 3.
- R4: Capture ends after N samples, where N is the latched count (0 counts as 1, and anything above DEPTH counts as DEPTH). The done flag rises on the edge exactly P*N cycles after the capture start.
- R5: Writing address 0 with bit0=1 and bit1=1 arms the block in free-run mode. Capture starts on that same write edge.
- R6: Writing address 0 with bit0=1 and bit1=0 arms the block in triggered mode. It waits until a START is seen: SDA synchronized from 1 to 0 while synchronized SCL is 1 in both consecutive samples. Capture starts on that edge, and the START is logged as event 0 with sample index 0.
- R7: While capturing, a START, a STOP (SDA from 0 to 1 while SCL stays 1) and every SCL rising edge are each logged as one event word. Bits [8:0] hold the number of samples stored before the event. Bits [10:9] hold the kind: 0 START, 1 STOP, 2 bit 0, 3 bit 1. The log is read at address 6 after the event index is written at address 5.
- R8: Bit 11 of an event word marks the acknowledge slot. It is set on the ninth SCL rising edge after arming or after the latest START, and on every ninth rising edge after that.
- R9: The log keeps at most EDEPTH events. Later events are dropped, and the event count (address 7) stays at EDEPTH.
- R10: The period and count are latched when the block is armed. Writes to them during waiting or capture do not change the timing of that capture.
- R11: The status word holds done in bit 2, capturing in bit 1 and waiting in bit 0. At most one of these bits is set at any time. Arming clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Observed SCL line |
| sda_in | input | 1 | Observed SDA line |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |

## Verification
The assertions check several properties on every cycle:
- the sample index never passes the latched count, and done implies a full buffer;
- the three status states exclude one another;
- arming in free-run mode, or a START while waiting, moves the block into capture on the next cycle;
- samples are spaced apart whenever the period exceeds one;
- the event count saturates at the log depth.

Other properties can only be shown by the bench's scenarios, which compare against a model built from the recorded line history:
- the exact cycle at which done rises;
- the line values stored in each sample;
- the kind, index and acknowledge flag of each logged event;
- the latched-config rule.

// File: rtl/i2c_cap_pkg.sv
package i2c_cap_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_BIT0  = 2'd2,
    EV_BIT1  = 2'd3
  } ev_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } cap_state_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_PER   = 3'd1;
  localparam logic [2:0] A_CNT   = 3'd2;
  localparam logic [2:0] A_SIDX  = 3'd3;
  localparam logic [2:0] A_SDAT  = 3'd4;
  localparam logic [2:0] A_EIDX  = 3'd5;
  localparam logic [2:0] A_EDAT  = 3'd6;
  localparam logic [2:0] A_ECNT  = 3'd7;

  // a zero period behaves as one cycle per sample
  function automatic logic [15:0] eff_period(input logic [15:0] p);
    return (p == 16'd0) ? 16'd1 : p;
  endfunction

  // sample count clamped to [1, depth]
  function automatic int unsigned eff_count(input logic [15:0] n, input int unsigned depth);
    if (n == 16'd0) return 1;
    if (32'(n) > depth) return depth;
    return 32'(n);
  endfunction

  // bit slot within a 9-bit byte frame, slot 8 is the acknowledge
  function automatic logic [3:0] next_slot(input logic [3:0] s);
    return (s >= 4'd8) ? 4'd0 : s + 4'd1;
  endfunction

endpackage

// File: rtl/i2c_cap_sync.sv
module i2c_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic rise_det
);
  logic [1:0] line_in;
  logic [1:0] line_s;
  logic [1:0] line_p;

  assign line_in = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_p <= 2'b11;
    else        line_p <= line_s;
  end

  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  assign start_det = line_s[1] & line_p[1] &  line_p[0] & ~line_s[0];
  assign stop_det  = line_s[1] & line_p[1] & ~line_p[0] &  line_s[0];
  assign rise_det  = line_s[1] & ~line_p[1];
endmodule

// File: rtl/i2c_cap_pacer.sv
module i2c_cap_pacer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  logic          run,
  input  logic [15:0]   period,
  input  logic [CW-1:0] count,
  output logic          tick,
  output logic          last,
  output logic [CW-1:0] idx
);
  logic [15:0] div;

  assign tick = run && (div == period - 16'd1);
  assign last = tick && (idx == count - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      idx <= '0;
    end else if (clr) begin
      div <= '0;
      idx <= '0;
    end else if (go) begin
      div <= '0;
    end else if (tick) begin
      div <= '0;
      idx <= idx + CW'(1);
    end else if (run) begin
      div <= div + 16'd1;
    end
  end
endmodule

// File: rtl/i2c_cap_store.sv
module i2c_cap_store #(
  parameter int DEPTH  = 256,
  parameter int EDEPTH = 32,
  parameter int EW     = 12,
  localparam int AW    = $clog2(DEPTH),
  localparam int EAW   = $clog2(EDEPTH),
  localparam int ECW   = $clog2(EDEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_we,
  input  logic [AW-1:0]  s_waddr,
  input  logic [1:0]     s_wdata,
  input  logic [AW-1:0]  s_raddr,
  output logic [1:0]     s_rdata,
  input  logic           e_clr,
  input  logic           e_push,
  input  logic [EW-1:0]  e_wdata,
  input  logic [EAW-1:0] e_raddr,
  output logic [EW-1:0]  e_rdata,
  output logic [ECW-1:0] e_cnt
);
  logic [1:0]    smem [DEPTH];
  logic [EW-1:0] emem [EDEPTH];
  logic          e_room;

  assign e_room = (e_cnt < ECW'(EDEPTH));

  always_ff @(posedge clk) begin
    if (s_we) smem[s_waddr] <= s_wdata;
    if (e_push && e_room && !e_clr) emem[e_cnt[EAW-1:0]] <= e_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 e_cnt <= '0;
    else if (e_clr)             e_cnt <= '0;
    else if (e_push && e_room)  e_cnt <= e_cnt + ECW'(1);
  end

  assign s_rdata = smem[s_raddr];
  assign e_rdata = emem[e_raddr];
endmodule

// File: rtl/i2c_capture_monitor.sv
module i2c_capture_monitor
  import i2c_cap_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int EDEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int EAW = $clog2(EDEPTH);
  localparam int ECW = $clog2(EDEPTH + 1);
  localparam int EW  = CW + 3;

  cap_state_t    state;
  logic [15:0]   per_reg, cnt_reg;
  logic [15:0]   act_per;
  logic [CW-1:0] act_cnt;
  logic [AW-1:0] sidx;
  logic [EAW-1:0] eidx;
  logic [3:0]    slot;
  logic          done;

  // named internal events for the checker
  logic          arm_wr, arm_free;
  logic          waiting, capturing;
  logic          scl_s, sda_s, start_det, stop_det, rise_det;
  logic          tick, last;
  logic [CW-1:0] samp_idx;
  logic          log_en, ev_any, ev_push;
  ev_kind_t      ev_kind;
  logic [EW-1:0] ev_word;
  logic [1:0]    s_rdata;
  logic [EW-1:0] e_rdata;
  logic [ECW-1:0] ev_cnt;

  assign arm_wr    = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0];
  assign arm_free  = cfg_wdata[1];
  assign waiting   = (state == ST_WAIT);
  assign capturing = (state == ST_CAPT);

  i2c_cap_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .rise_det(rise_det)
  );

  i2c_cap_pacer #(.CW(CW)) u_pacer (
    .clk(clk), .rst_n(rst_n),
    .clr(arm_wr),
    .go(waiting && start_det && !arm_wr),
    .run(capturing && !arm_wr),
    .period(act_per), .count(act_cnt),
    .tick(tick), .last(last), .idx(samp_idx)
  );

  // event classification
  assign log_en = !arm_wr && (capturing || (waiting && start_det));
  assign ev_any = start_det || stop_det || rise_det;
  assign ev_push = log_en && ev_any;

  always_comb begin
    if (start_det)      ev_kind = EV_START;
    else if (stop_det)  ev_kind = EV_STOP;
    else if (sda_s)     ev_kind = EV_BIT1;
    else                ev_kind = EV_BIT0;
  end

  assign ev_word = {(rise_det && slot == 4'd8), ev_kind, samp_idx};

  i2c_cap_store #(.DEPTH(DEPTH), .EDEPTH(EDEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .s_we(tick), .s_waddr(samp_idx[AW-1:0]), .s_wdata({scl_s, sda_s}),
    .s_raddr(sidx), .s_rdata(s_rdata),
    .e_clr(arm_wr), .e_push(ev_push), .e_wdata(ev_word),
    .e_raddr(eidx), .e_rdata(e_rdata), .e_cnt(ev_cnt)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_reg <= '0;
      cnt_reg <= '0;
      sidx    <= '0;
      eidx    <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_PER:  per_reg <= cfg_wdata;
        A_CNT:  cnt_reg <= cfg_wdata;
        A_SIDX: sidx    <= cfg_wdata[AW-1:0];
        A_EIDX: eidx    <= cfg_wdata[EAW-1:0];
        default: ;
      endcase
    end
  end

  // control state, latched settings, byte slot tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      act_per <= 16'd1;
      act_cnt <= CW'(1);
      slot    <= '0;
    end else begin
      if (arm_wr) begin
        act_per <= eff_period(per_reg);
        act_cnt <= CW'(eff_count(cnt_reg, DEPTH));
        done    <= 1'b0;
        slot    <= '0;
        state   <= arm_free ? ST_CAPT : ST_WAIT;
      end else begin
        if (start_det)     slot <= '0;
        else if (rise_det) slot <= next_slot(slot);
        case (state)
          ST_WAIT: if (start_det) state <= ST_CAPT;
          ST_CAPT: if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      A_CTRL:  cfg_rdata = {13'd0, done, capturing, waiting};
      A_PER:   cfg_rdata = per_reg;
      A_CNT:   cfg_rdata = cnt_reg;
      A_SIDX:  cfg_rdata = 16'(sidx);
      A_SDAT:  cfg_rdata = 16'(s_rdata);
      A_EIDX:  cfg_rdata = 16'(eidx);
      A_EDAT:  cfg_rdata = 16'(e_rdata);
      default: cfg_rdata = 16'(ev_cnt);
    endcase
  end
endmodule

// File: rtl/i2c_cap_checker.sv
module i2c_cap_checker #(
  parameter int DEPTH  = 256,
  parameter int EDEPTH = 32,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int ECW   = $clog2(EDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           capturing,
  input logic           waiting,
  input logic           done,
  input logic           arm_wr,
  input logic           arm_free,
  input logic           start_det,
  input logic [CW-1:0]  samp_idx,
  input logic [CW-1:0]  act_cnt,
  input logic [15:0]    act_per,
  input logic [ECW-1:0] ev_cnt
);
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_idx <= act_cnt);

  p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (samp_idx == act_cnt));

  p_state_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, capturing, waiting}));

  p_free_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_free) |=> capturing);

  p_trig_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && start_det && !arm_wr) |=> capturing);

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_per != 16'd1) |=> !tick);

  p_ev_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt <= ECW'(EDEPTH));

  p_ev_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnt == ECW'(EDEPTH) && !arm_wr) |=> (ev_cnt == ECW'(EDEPTH)));
endmodule

bind i2c_capture_monitor i2c_cap_checker #(.DEPTH(DEPTH), .EDEPTH(EDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .capturing(capturing),
  .waiting(waiting), .done(done), .arm_wr(arm_wr), .arm_free(arm_free),
  .start_det(start_det), .samp_idx(samp_idx), .act_cnt(act_cnt),
  .act_per(act_per), .ev_cnt(ev_cnt)
);

// File: tb/i2c_capture_monitor_tb.sv
module i2c_capture_monitor_tb;
  localparam int DEPTH  = 256;
  localparam int EDEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;

  int n_chk = 0, n_bad = 0;
  int ecnt = 0;
  logic [1:0] hist [8192];
  int exp_ev [EDEPTH];

  always #2 clk = ~clk;

  i2c_capture_monitor #(.DEPTH(DEPTH), .EDEPTH(EDEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // line history indexed by edge number
  always @(posedge clk) begin
    hist[ecnt & 8191] = {scl, sda};
    ecnt = ecnt + 1;
  end

  function automatic logic [1:0] hv(int c);
    return hist[c & 8191];
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = int'(cfg_rdata);
  endtask

  task automatic hold(int h);
    repeat (h) @(negedge clk);
  endtask

  task automatic bus_xfer(int nbytes, int h);
    sda = 1'b0; hold(h);
    scl = 1'b0; hold(h);
    for (int b = 0; b < nbytes * 9; b++) begin
      sda = 1'($urandom);
      hold(h);
      scl = 1'b1; hold(h);
      scl = 1'b0;
    end
    sda = 1'b0; hold(h);
    scl = 1'b1; hold(h);
    sda = 1'b1; hold(h);
  endtask

  task automatic run_cap(int per_w, int cnt_w, bit free, int nbytes, int h, int pre, bit midw);
    int p, n, a, e, A, don, d, st, bp, ne, k, ix, ack;
    logic [1:0] s, q;
    wr(3'd1, per_w);
    wr(3'd2, cnt_w);
    rd(3'd1, d); chk("R2 period readback", d, per_w);
    rd(3'd2, d); chk("R2 count readback", d, cnt_w);
    p = (per_w == 0) ? 1 : per_w;
    n = (cnt_w == 0) ? 1 : ((cnt_w > DEPTH) ? DEPTH : cnt_w);
    A = 0; don = 0;
    fork
      begin hold(pre); bus_xfer(nbytes, h); end
      begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = {14'd0, free, 1'b1};
        A = ecnt;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 3'd0;
        #1 st = int'(cfg_rdata);
        if (free) chk("R5 capturing after free-run arm", st, 2);
        else      chk("R6 waiting after triggered arm", st, 1);
        if (midw) begin
          wr(3'd1, 7);
          wr(3'd2, 3);
          cfg_addr = 3'd0;
        end
        forever begin
          @(negedge clk);
          #1;
          if (cfg_rdata[2]) break;
        end
        don = ecnt - 1;
      end
    join
    // capture start edge from the recorded history
    a = A;
    if (!free) begin
      for (int c = A + 1; c < A + 8000; c++) begin
        s = hv(c - 2); q = hv(c - 3);
        if (s[1] && q[1] && q[0] && !s[0]) begin a = c; break; end
      end
    end
    e = a + p * n;
    chk("R4 done edge", don, e);
    rd(3'd0, d); chk("R11 status after done", d, 4);
    for (int j = 0; j < n; j++) begin
      wr(3'd3, j);
      rd(3'd4, d);
      chk("R3 sample value", d, int'(hv(a + p * (j + 1) - 2)));
    end
    // expected event log
    bp = 0; ne = 0;
    for (int c = (free ? A + 1 : a); c <= e; c++) begin
      s = hv(c - 2); q = hv(c - 3);
      k = -1; ack = 0;
      if (s[1] && q[1] && q[0] && !s[0])       begin k = 0; bp = 0; end
      else if (s[1] && q[1] && !q[0] && s[0])  k = 1;
      else if (s[1] && !q[1]) begin
        k = 2 + int'(s[0]);
        ack = (bp == 8) ? 1 : 0;
        bp = (bp >= 8) ? 0 : bp + 1;
      end
      if (k >= 0) begin
        ix = (c <= a) ? 0 : (c - a - 1) / p;
        if (ix > n) ix = n;
        if (ne < EDEPTH) exp_ev[ne] = (ack << 11) | (k << 9) | ix;
        ne++;
      end
    end
    if (ne > EDEPTH) ne = EDEPTH;
    rd(3'd7, d); chk("R9 event count", d, ne);
    for (int i = 0; i < ne; i++) begin
      wr(3'd5, i);
      rd(3'd6, d);
      chk("R7 R8 event word", d, exp_ev[i]);
      if (i == 0 && !free) chk("R6 first event is START at 0", d, 0);
    end
    if (midw) begin
      rd(3'd1, d); chk("R10 period reg holds new write", d, 7);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, d); chk("R1 status after reset", d, 0);
    rd(3'd7, d); chk("R1 event count after reset", d, 0);
    rd(3'd1, d); chk("R1 period after reset", d, 0);
    run_cap(3, 40, 1'b1, 3, 2, 4, 1'b0);
    run_cap(1, 60, 1'b0, 2, 3, 20, 1'b0);
    run_cap(0, 0, 1'b1, 1, 2, 3, 1'b0);
    run_cap(1, 300, 1'b1, 2, 2, 5, 1'b0);
    run_cap(8, 150, 1'b0, 4, 3, 30, 1'b1);
    for (int r = 0; r < 6; r++) begin
      run_cap(1 + int'($urandom % 4), 1 + int'($urandom % 120), 1'($urandom),
              1 + int'($urandom % 3), 2 + int'($urandom % 3), 5 + int'($urandom % 25),
              1'b0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule